// File: doc/BRIEF.md
# Busy-Flagged Serial Converter Readout Sequencer

This block sits on the host side of a serial successive-approximation converter. The converter is wired so that a convert line starts each sample, a select line chooses the readout, and a shared data line has an external pull-up. A single-cycle request on `start_i` raises the convert line while the select line is still high, which starts a conversion. The select line then drops after a fixed number of clocks. Because it is low when the conversion finishes, the converter signals completion by driving the data line low.

The sequencer passes the data line through a synchronizer and waits for that high-to-low change. No fixed conversion delay is assumed. When the change arrives, the sequencer runs a divided serial clock and collects the result MSB first, with one bit taken on each falling edge. After the last edge it raises the select line, drops the convert line and presents the word with a one-cycle strobe. If the completion edge does not arrive within a run-time limit, the frame is abandoned and an error pulse is given.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While `rst_ni` is low and in idle afterwards, `cnv_o`=0, `sdi_o`=1, `sck_o`=0, `valid_o`=0 and `error_o`=0.
- R2: A `start_i` sampled high in idle sets `cnv_o` on the next clock while `sdi_o` stays high. `sdi_o` stays high for exactly `SDI_HI_CYC` cycles in which `cnv_o` is high, then stays low until the frame ends.
- R3: `cnv_o` stays high through the conversion wait and the whole readback. It falls in the same cycle that `valid_o` or `error_o` is high.
- R4: End of conversion is recognised only as a 1-to-0 change of `sdo_i` after a two-flop synchronizer. No `sck_o` pulse occurs before the converter has pulled the line low.
- R5: A readback issues exactly `DATA_W+1` falling edges of `sck_o`. The level at the first falling edge is the busy marker and is discarded. The bit that the converter drives after falling edge k is taken at falling edge k+1. The first bit taken is bit `DATA_W-1`, so `data_o[DATA_W-1]` holds the first bit and `data_o[0]` the last.
- R6: `sck_o` is low outside readback. Inside readback, each high phase and each low phase that follows a fall lasts max(`sck_half_i`,2) clock cycles.
- R7: `valid_o` is high for one cycle with the new word on `data_o`. `data_o` then holds that word until the next `valid_o`.
- R8: If no end-of-conversion edge is seen, the conversion wait ends after `tmo_limit_i`+1 cycles. `error_o` pulses for one cycle and `cnv_o` falls with it, so `cnv_o` has been high for `SDI_HI_CYC`+`tmo_limit_i`+1 cycles. `sdi_o` returns high and `valid_o` stays low.
- R9: `start_i` has no effect outside idle. No second conversion begins until the current frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, acted on in idle |
| sck_half_i | input | DIV_W | Serial clock half-period in clock cycles, minimum 2 |
| tmo_limit_i | input | TMO_W | Conversion wait limit in cycles, minus one |
| sdo_i | input | 1 | Converter data line, pulled high when released |
| cnv_o | output | 1 | Convert line to converter |
| sdi_o | output | 1 | Select line to converter |
| sck_o | output | 1 | Serial clock to converter |
| data_o | output | DATA_W | Last captured word |
| valid_o | output | 1 | One-cycle strobe for a new word |
| error_o | output | 1 | One-cycle pulse when the conversion wait times out |

## Verification
The bench builds the sequencer with `DATA_W`=8, `SDI_HI_CYC`=3, `DIV_W`=4 and `TMO_W`=12. The 8-bit word width lets every code pass through a modelled converter, which checks both bit ordering and the discarded busy marker. Half-periods from 0 to 6 cover the clamp at 2 and several divider settings. Conversion times of several lengths and a converter that never responds, used with different wait limits, check the exact timeout length and a restart after an abandoned frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CONV,
    ST_READ,
    ST_DONE
  } rd_state_e;
endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             fall_o
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_eff;
  logic             sck_q;
  logic             tick;

  assign half_eff = (half_i < MIN_HALF) ? MIN_HALF : half_i;
  assign tick     = run_i && (cnt_q == half_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign sck_o  = sck_q;
  assign fall_o = tick && sck_q;

  assert_high_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_q) |=> sck_q);
  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_q);
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic [W-1:0] word_next_o
);
  logic [W-1:0] word_q;

  assign word_next_o = {word_q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (en_i) word_q <= word_next_o;
  end

  assign word_o = word_q;
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 8,
  parameter int TMO_W      = 16,
  parameter int SDI_HI_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  sck_half_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sdi_o,
  output logic              sck_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              error_o
);
  localparam int FCNT_W = $clog2(DATA_W + 1);
  localparam int HCNT_W = $clog2(SDI_HI_CYC + 1);
  localparam logic [FCNT_W-1:0] LAST_FALL = FCNT_W'(DATA_W);
  localparam logic [HCNT_W-1:0] LAST_HI   = HCNT_W'(SDI_HI_CYC - 1);

  rd_state_e         state_q;
  logic [HCNT_W-1:0] hcnt_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [FCNT_W-1:0] fcnt_q;
  logic              err_q;
  logic [DATA_W-1:0] data_q;
  logic              sdo_s, sdo_prev_q, busy_fall;
  logic              run_sck, sck_fall, cap_en;
  logic [DATA_W-1:0] shift_word, shift_next;

  adc_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sdo_i),
    .q_o   (sdo_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_prev_q <= 1'b1;
    else         sdo_prev_q <= sdo_s;
  end
  assign busy_fall = sdo_prev_q && !sdo_s;

  assign run_sck = (state_q == ST_READ);

  adc_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_sck),
    .half_i(sck_half_i),
    .sck_o (sck_o),
    .fall_o(sck_fall)
  );

  // first fall only shows the busy marker
  assign cap_en = sck_fall && (fcnt_q != '0);

  adc_shift_in #(.W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cap_en),
    .bit_i      (sdo_s),
    .word_o     (shift_word),
    .word_next_o(shift_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      tmo_q   <= '0;
      fcnt_q  <= '0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_START;
            hcnt_q  <= '0;
          end
        end
        ST_START: begin
          if (hcnt_q == LAST_HI) begin
            state_q <= ST_CONV;
            tmo_q   <= '0;
          end else begin
            hcnt_q <= hcnt_q + HCNT_W'(1);
          end
        end
        ST_CONV: begin
          if (busy_fall) begin
            state_q <= ST_READ;
            fcnt_q  <= '0;
          end else if (tmo_q == tmo_limit_i) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else begin
            tmo_q <= tmo_q + TMO_W'(1);
          end
        end
        ST_READ: begin
          if (sck_fall) begin
            if (fcnt_q == LAST_FALL) begin
              state_q <= ST_DONE;
              data_q  <= shift_next;
            end else begin
              fcnt_q <= fcnt_q + FCNT_W'(1);
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o   = (state_q == ST_START) || (state_q == ST_CONV) || (state_q == ST_READ);
  assign sdi_o   = !((state_q == ST_CONV) || (state_q == ST_READ));
  assign valid_o = (state_q == ST_DONE);
  assign error_o = err_q;
  assign data_o  = data_q;

  assert_cnv_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_o) |-> (valid_o || error_o));
  assert_sdi_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdi_o) |-> !cnv_o);
  assert_no_sck_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> (cnv_o && !sdi_o && !(state_q == ST_CONV)));
  assert_fall_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ) |-> (fcnt_q <= LAST_FALL));
  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> (!valid_o || $stable(data_o) || $past(state_q == ST_READ)));
  assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);
  assert_start_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> $past(start_i));
endmodule

// File: tb/adc_readout_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_readout_ctrl_tb_top;
  localparam int DW  = 8;
  localparam int HI  = 3;
  localparam int DVW = 4;
  localparam int TW  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DVW-1:0] half = DVW'(2);
  logic [TW-1:0] tmo = TW'(100);
  logic          sdo;
  logic          cnv, sdi, sck, valid, err;
  logic [DW-1:0] data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic          dev_en = 1'b0, dev_bit = 1'b1, dev_dead = 1'b0;
  logic [DW-1:0] dev_word = '0;
  int            conv_ns = 200;
  int            sck_falls = 0;

  always #10 clk = ~clk;

  assign sdo = dev_en ? dev_bit : 1'b1;

  adc_readout_ctrl #(.DATA_W(DW), .DIV_W(DVW), .TMO_W(TW), .SDI_HI_CYC(HI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sck_half_i(half),
    .tmo_limit_i(tmo), .sdo_i(sdo), .cnv_o(cnv), .sdi_o(sdi), .sck_o(sck),
    .data_o(data), .valid_o(valid), .error_o(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: busy low, then one bit after each falling edge
  initial begin
    forever begin
      @(posedge cnv);
      if (sdi !== 1'b1) continue;
      #(conv_ns);
      if (dev_dead || !cnv) continue;
      dev_en = 1'b1;
      dev_bit = 1'b0;
      for (int k = 1; k <= DW + 1; k++) begin
        @(negedge sck or posedge sdi);
        if (sdi) break;
        #1;
        if (k <= DW) dev_bit = dev_word[DW-k];
      end
      dev_en = 1'b0;
    end
  end

  always @(negedge sck) sck_falls++;

  // R4: no serial clock before busy low
  always @(posedge sck) chk(dev_en === 1'b1, "R4 sck before busy", sck, 0);

  // R6: phase lengths
  logic sck_prev = 1'b0;
  int   ph = 0;
  bit   after_fall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_h;
      exp_h = (half < 2) ? 2 : int'(half);
      if (sck == sck_prev) ph++;
      else begin
        if (sck_prev) begin
          chk(ph == exp_h, "R6 high phase", ph, exp_h);
          after_fall = 1;
        end else if (after_fall) begin
          chk(ph == exp_h, "R6 low phase", ph, exp_h);
        end
        ph = 1;
      end
      if (!cnv) begin
        after_fall = 0;
        chk(sck == 1'b0, "R6 sck idle low", sck, 0);
      end
      sck_prev = sck;
    end
  end

  task automatic frame(input logic [DW-1:0] w, input int hf, input int cns,
                       input bit dead, input bit poke);
    int cyc, hi_cnt;
    bit seen_low;
    dev_word = w; conv_ns = cns; dev_dead = dead; half = DVW'(hf);
    sck_falls = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cnv && sdi, "R2 cnv rises with sdi high", {cnv, sdi}, 2'b11);
    cyc = 1; hi_cnt = 1; seen_low = 0;
    while (!valid && !err && cyc < 3000) begin
      @(negedge clk); cyc++;
      start = (poke && cyc == HI + 12);
      if (!seen_low && !valid && !err) begin
        if (sdi) hi_cnt++;
        else begin
          seen_low = 1;
          chk(hi_cnt == HI, "R2 sdi high cycles", hi_cnt, HI);
        end
      end else if (seen_low && !valid && !err) begin
        chk(!sdi && cnv, "R3 lines held in frame", {cnv, sdi}, 2'b10);
      end
    end
    start = 1'b0;
    if (dead) begin
      chk(err && !valid, "R8 error pulse", {err, valid}, 2'b10);
      chk(cyc == HI + int'(tmo) + 2, "R8 wait length", cyc, HI + int'(tmo) + 2);
      chk(!cnv && sdi, "R8 lines released", {cnv, sdi}, 2'b01);
      @(negedge clk);
      chk(!err, "R8 error one cycle", err, 0);
    end else begin
      chk(valid, "R7 valid seen", valid, 1);
      chk(data == w, "R5 captured word", data, w);
      chk(!cnv && sdi, "R3 cnv drops with valid", {cnv, sdi}, 2'b01);
      chk(sck_falls == DW + 1, "R5 falling edge count", sck_falls, DW + 1);
      @(negedge clk);
      chk(!valid && data == w, "R7 pulse and hold", {valid, data}, {1'b0, w});
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (poke) chk(!cnv, "R9 start ignored", cnv, 0);
    end
  endtask

  initial begin
    #5;
    chk(!cnv && sdi && !sck && !valid && !err, "R1 reset outputs",
        {cnv, sdi, sck, valid, err}, 5'b01000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cnv && sdi && !sck && !valid && !err, "R1 idle outputs",
        {cnv, sdi, sck, valid, err}, 5'b01000);

    for (int w = 0; w < (1 << DW); w++) frame(DW'(w), 2, 200, 0, 0);

    for (int hf = 0; hf <= 6; hf++) begin
      frame(8'hA5, hf, 100 + 60 * hf, 0, 0);
      frame(8'h5A, hf, 300, 0, 0);
      frame(8'h00, hf, 150, 0, 0);
      frame(8'hFF, hf, 450, 0, 0);
    end

    tmo = TW'(5);  frame(8'h3C, 2, 200, 1, 0);
    tmo = TW'(17); frame(8'h3C, 3, 200, 1, 0);
    tmo = TW'(40); frame(8'h3C, 2, 200, 1, 0);
    tmo = TW'(100);
    frame(8'hC3, 2, 200, 0, 0);
    frame(8'h81, 3, 200, 0, 1);
    frame(8'h7E, 2, 200, 0, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R1-watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule